// File: doc/BRIEF.md
# Output Compare Toggle Unit

This block watches a free-running 16-bit timer count and compares it against four software-programmed compare values. When a compare value equals the count, the channel's interrupt flag is set and the waveform pin tied to that channel changes level. A waveform can therefore be built from a series of timed edges without software reacting to each match. A single comparator is shared by all channels: a scan pointer visits one channel per clock.

Each channel has its own sticky flag and its own masked interrupt request. Each pin can be loaded with a starting level before compare activity begins. A pairing mode lets two compare registers drive the same pin, so that one register places the rising edge and the other places the falling edge of a pulse. The match of compare register 0 is also exported so that the timer can clear itself on it. The timer must hold each count value for at least as many clocks as there are channels. A divided timer clock of four or more meets this for the default four channels.

Top module: `ocmp_toggle_unit`

## Requirements
- R1: After reset every pin is 0, every flag and interrupt request is 0, and every compare register is 0. A zero register therefore matches a zero count once, which is visible as one pulse on `cmp0_match`.
- R2: Suppose an enabled channel's compare value equals the timer count, and the count is held for four clocks. By the end of those clocks the channel's flag (bit i of `flag_o` for channel i) is set, and its pin has inverted.
- R3: A channel matches once for each count value. Holding an equal count for several scan rounds inverts the pin only once. The channel matches again only after the count has been seen at some other value.
- R4: When `pair_mode` is 0, channel 2k inverts pin k (bit k of `wave_o`). Channels 2k+1 still set their flags but leave every pin unchanged.
- R5: When `pair_mode` is 1, a match on channel 2k or on channel 2k+1 inverts pin k.
- R6: A channel whose `ch_en` bit is 0 never sets its flag and never inverts a pin.
- R7: A flag stays set until a clock with the matching `flag_clr` bit high clears it. If a match and a clear reach the same channel in the same clock, the match wins.
- R8: `irq_o[i]` is high exactly when flag i is set and `irq_en[i]` is high. It follows `irq_en` with no clock delay.
- R9: A clock with `pin_init_we[k]` high loads `pin_init_val[k]` into pin k, and the new level shows on the next clock. If a match would invert the pin in that same clock, the load wins.
- R10: `cmp0_match` pulses for one clock each time compare register 0 matches a count value, whatever the state of `ch_en[0]`.
- R11: Writing a compare register makes the channel ready to match again. If the written value equals the count being held, the channel matches within four clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmr_cnt | input | 16 | Current free-running timer count |
| cmp_we | input | 4 | Per-channel compare register write strobe |
| cmp_wdata | input | 16 | Compare value written on a strobe |
| ch_en | input | 4 | Per-channel compare enable |
| irq_en | input | 4 | Per-channel interrupt enable |
| flag_clr | input | 4 | Per-channel flag clear (one clock) |
| pair_mode | input | 1 | 0: one register per pin, 1: two registers per pin |
| pin_init_we | input | 2 | Per-pin initial-level load strobe |
| pin_init_val | input | 2 | Level loaded on a pin strobe |
| wave_o | output | 2 | Waveform pin levels |
| flag_o | output | 4 | Sticky match flags |
| irq_o | output | 4 | Masked interrupt requests |
| cmp0_match | output | 1 | One-clock pulse on a compare register 0 match |

## Verification
Suppose a ready-to-match bit is stuck clear. The channel then stops matching, and within one scan round its flag fails to set and its pin fails to invert. If that bit fails to clear, the pin inverts again on every scan round, which is four clocks apart, so holding a count for eight clocks shows a doubled toggle at once. A scan pointer that skips a channel, or a wrong channel-to-pin map, shows up as a flag or a pin that does not change, or that changes for the wrong channel, by the end of the four-clock window that follows each count change. The bench holds each count for whole scan rounds so that it does not depend on the pointer's phase.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;

    typedef enum logic {
        PIN_MAP_SINGLE = 1'b0,
        PIN_MAP_PAIRED = 1'b1
    } pin_map_e;

    function automatic int unsigned ptr_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/ocmp_scanner.sv
module ocmp_scanner #(
    parameter int unsigned CH_N  = 4,
    parameter int unsigned CNT_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CNT_W-1:0]     tmr_cnt,
    input  logic [CH_N-1:0]      cmp_we,
    input  logic [CNT_W-1:0]     cmp_wdata,
    output logic [CH_N-1:0]      match_o
);
    localparam int unsigned PTR_W = ocmp_pkg::ptr_width(CH_N);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(CH_N - 1);

    typedef struct packed {
        logic [CH_N-1:0][CNT_W-1:0] cmp;
        logic [CH_N-1:0]            armed;
        logic [PTR_W-1:0]           ptr;
    } scan_t;

    scan_t s_d, s_q;
    logic  eq;

    always_comb begin
        s_d     = s_q;
        match_o = '0;
        eq      = (s_q.cmp[s_q.ptr] == tmr_cnt);
        if (eq && s_q.armed[s_q.ptr]) begin
            match_o[s_q.ptr] = 1'b1;
        end
        s_d.armed[s_q.ptr] = ~eq;
        s_d.ptr = (s_q.ptr == PTR_LAST) ? '0 : s_q.ptr + PTR_W'(1);
        for (int i = 0; i < CH_N; i++) begin
            if (cmp_we[i]) begin
                s_d.cmp[i]   = cmp_wdata;
                s_d.armed[i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.cmp   <= '0;
            s_q.armed <= '1;
            s_q.ptr   <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    AST_SCAN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_o)); // R2

    generate
        if (CH_N > 1) begin : g_gap
            for (genvar i = 0; i < CH_N; i++) begin : g_ch
                AST_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
                    match_o[i] |=> !match_o[i]); // R3
            end
        end
    endgenerate

endmodule

// File: rtl/ocmp_flags.sv
module ocmp_flags #(
    parameter int unsigned CH_N = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CH_N-1:0] match_i,
    input  logic [CH_N-1:0] ch_en,
    input  logic [CH_N-1:0] irq_en,
    input  logic [CH_N-1:0] flag_clr,
    output logic [CH_N-1:0] flag_o,
    output logic [CH_N-1:0] irq_o
);
    typedef struct packed {
        logic [CH_N-1:0] flag;
    } flag_t;

    flag_t f_d, f_q;

    always_comb begin
        f_d      = f_q;
        f_d.flag = (f_q.flag & ~flag_clr) | (match_i & ch_en);
        flag_o   = f_q.flag;
        irq_o    = f_q.flag & irq_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    generate
        for (genvar i = 0; i < CH_N; i++) begin : g_ch
            AST_FLAG_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(f_q.flag[i]) |-> $past(ch_en[i])); // R6
            AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
                (f_q.flag[i] && !flag_clr[i]) |=> f_q.flag[i]); // R7
        end
    endgenerate

endmodule

// File: rtl/ocmp_pins.sv
module ocmp_pins #(
    parameter int unsigned PIN_N = 2,
    parameter int unsigned CH_N  = 2 * PIN_N
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CH_N-1:0]  match_i,
    input  logic [CH_N-1:0]  ch_en,
    input  logic             pair_mode,
    input  logic [PIN_N-1:0] init_we,
    input  logic [PIN_N-1:0] init_val,
    output logic [PIN_N-1:0] pin_o
);
    import ocmp_pkg::*;

    typedef struct packed {
        logic [PIN_N-1:0] pin;
    } pin_t;

    pin_t             p_d, p_q;
    logic [PIN_N-1:0] tog;
    pin_map_e         map;

    always_comb begin
        map = pin_map_e'(pair_mode);
        p_d = p_q;
        for (int k = 0; k < PIN_N; k++) begin
            tog[k] = match_i[2*k] & ch_en[2*k];
            if (map == PIN_MAP_PAIRED) begin
                tog[k] = tog[k] | (match_i[2*k+1] & ch_en[2*k+1]);
            end
            p_d.pin[k] = init_we[k] ? init_val[k] : (p_q.pin[k] ^ tog[k]);
        end
        pin_o = p_q.pin;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    generate
        for (genvar k = 0; k < PIN_N; k++) begin : g_pin
            AST_PIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
                (!init_we[k] && !match_i[2*k] && !match_i[2*k+1]) |=> $stable(p_q.pin[k])); // R6
            AST_ODD_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
                (!pair_mode && !init_we[k] && !match_i[2*k]) |=> $stable(p_q.pin[k])); // R4
            AST_INIT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
                init_we[k] |=> (p_q.pin[k] == $past(init_val[k]))); // R9
        end
    endgenerate

endmodule

// File: rtl/ocmp_toggle_unit.sv
module ocmp_toggle_unit #(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned PIN_N = 2,
    localparam int unsigned CH_N = 2 * PIN_N
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] tmr_cnt,
    input  logic [CH_N-1:0]  cmp_we,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic [CH_N-1:0]  ch_en,
    input  logic [CH_N-1:0]  irq_en,
    input  logic [CH_N-1:0]  flag_clr,
    input  logic             pair_mode,
    input  logic [PIN_N-1:0] pin_init_we,
    input  logic [PIN_N-1:0] pin_init_val,
    output logic [PIN_N-1:0] wave_o,
    output logic [CH_N-1:0]  flag_o,
    output logic [CH_N-1:0]  irq_o,
    output logic             cmp0_match
);
    logic [CH_N-1:0] match;

    ocmp_scanner #(.CH_N(CH_N), .CNT_W(CNT_W)) u_scan (
        .clk       (clk),
        .rst_n     (rst_n),
        .tmr_cnt   (tmr_cnt),
        .cmp_we    (cmp_we),
        .cmp_wdata (cmp_wdata),
        .match_o   (match)
    );

    ocmp_flags #(.CH_N(CH_N)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .match_i  (match),
        .ch_en    (ch_en),
        .irq_en   (irq_en),
        .flag_clr (flag_clr),
        .flag_o   (flag_o),
        .irq_o    (irq_o)
    );

    ocmp_pins #(.PIN_N(PIN_N), .CH_N(CH_N)) u_pins (
        .clk       (clk),
        .rst_n     (rst_n),
        .match_i   (match),
        .ch_en     (ch_en),
        .pair_mode (pair_mode),
        .init_we   (pin_init_we),
        .init_val  (pin_init_val),
        .pin_o     (wave_o)
    );

    assign cmp0_match = match[0];

    AST_CMP0_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cmp0_match |=> !cmp0_match); // R10

endmodule

// File: tb/tb_ocmp_toggle_unit.sv
module tb_ocmp_toggle_unit;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] tmr_cnt = '0;
    logic [3:0]  cmp_we = '0;
    logic [15:0] cmp_wdata = '0;
    logic [3:0]  ch_en = '0;
    logic [3:0]  irq_en = '0;
    logic [3:0]  flag_clr = '0;
    logic        pair_mode = 1'b0;
    logic [1:0]  pin_init_we = '0;
    logic [1:0]  pin_init_val = '0;
    logic [1:0]  wave_o;
    logic [3:0]  flag_o;
    logic [3:0]  irq_o;
    logic        cmp0_match;

    ocmp_toggle_unit dut (
        .clk(clk), .rst_n(rst_n), .tmr_cnt(tmr_cnt), .cmp_we(cmp_we),
        .cmp_wdata(cmp_wdata), .ch_en(ch_en), .irq_en(irq_en),
        .flag_clr(flag_clr), .pair_mode(pair_mode), .pin_init_we(pin_init_we),
        .pin_init_val(pin_init_val), .wave_o(wave_o), .flag_o(flag_o),
        .irq_o(irq_o), .cmp0_match(cmp0_match)
    );

    always #(CLK_P/2) clk = ~clk;

    typedef enum int {K_PINS, K_FLAGS, K_IRQ, K_C0} kind_e;
    typedef struct {
        kind_e      kind;
        logic [7:0] exp;
        string      req;
    } item_t;

    item_t q[$];
    int    checks = 0;
    int    errors = 0;
    int    c0_cnt = 0;
    bit    done = 1'b0;

    // Monitor: counts register 0 pulses and compares queued expectations.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (cmp0_match === 1'b1) c0_cnt++;
            while (q.size() > 0) begin
                item_t      it;
                logic [7:0] act;
                it = q.pop_front();
                case (it.kind)
                    K_PINS:  act = {6'd0, wave_o};
                    K_FLAGS: act = {4'd0, flag_o};
                    K_IRQ:   act = {4'd0, irq_o};
                    default: act = 8'(c0_cnt);
                endcase
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s %s actual=%0h expected=%0h", it.req, it.kind.name(), act, it.exp);
                end
            end
        end
    end

    task automatic expect_item(input kind_e k, input logic [7:0] e, input string r);
        item_t it;
        it.kind = k; it.exp = e; it.req = r;
        q.push_back(it);
    endtask

    task automatic hold(input logic [15:0] v, input int n);
        tmr_cnt = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_cmp(input int ch, input logic [15:0] v);
        cmp_we = '0;
        cmp_we[ch] = 1'b1;
        cmp_wdata = v;
        @(negedge clk);
        cmp_we = '0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        c0_cnt = 0;
        hold(16'd0, 4);
        expect_item(K_PINS, 8'h0, "R1");
        expect_item(K_FLAGS, 8'h0, "R1");
        expect_item(K_IRQ, 8'h0, "R1");
        expect_item(K_C0, 8'd1, "R1");

        wr_cmp(0, 16'd100);
        wr_cmp(1, 16'd200);
        wr_cmp(2, 16'd300);
        wr_cmp(3, 16'd400);
        ch_en = 4'b1111;
        irq_en = 4'b0101;

        hold(16'd100, 4);
        expect_item(K_PINS, 8'h1, "R2");
        expect_item(K_FLAGS, 8'h1, "R2");
        expect_item(K_IRQ, 8'h1, "R8");
        hold(16'd200, 4);
        expect_item(K_PINS, 8'h1, "R4");
        expect_item(K_FLAGS, 8'h3, "R4");
        expect_item(K_IRQ, 8'h1, "R8");
        hold(16'd300, 8);
        expect_item(K_PINS, 8'h3, "R3");
        expect_item(K_FLAGS, 8'h7, "R4");
        hold(16'd301, 4);
        expect_item(K_FLAGS, 8'h7, "R7");
        hold(16'd300, 4);
        expect_item(K_PINS, 8'h1, "R3");

        tmr_cnt = 16'd301;
        flag_clr = 4'b1111;
        @(negedge clk);
        flag_clr = '0;
        @(negedge clk);
        expect_item(K_FLAGS, 8'h0, "R7");

        ch_en = 4'b1110;
        hold(16'd100, 4);
        expect_item(K_PINS, 8'h1, "R6");
        expect_item(K_FLAGS, 8'h0, "R6");

        ch_en = 4'b1111;
        pair_mode = 1'b1;
        hold(16'd200, 4);
        expect_item(K_PINS, 8'h0, "R5");
        hold(16'd400, 4);
        expect_item(K_PINS, 8'h2, "R5");
        expect_item(K_FLAGS, 8'ha, "R5");

        irq_en = 4'b1111;
        @(negedge clk);
        expect_item(K_IRQ, 8'ha, "R8");

        pin_init_we = 2'b11;
        pin_init_val = 2'b01;
        @(negedge clk);
        pin_init_we = '0;
        expect_item(K_PINS, 8'h1, "R9");

        pair_mode = 1'b0;
        ch_en = 4'b1110;
        c0_cnt = 0;
        hold(16'd100, 12);
        expect_item(K_C0, 8'd1, "R10");
        expect_item(K_PINS, 8'h1, "R10");
        expect_item(K_FLAGS, 8'ha, "R10");

        ch_en = 4'b1111;
        hold(16'd555, 4);
        expect_item(K_PINS, 8'h1, "R11");
        wr_cmp(2, 16'd555);
        repeat (4) @(negedge clk);
        expect_item(K_PINS, 8'h3, "R11");
        expect_item(K_FLAGS, 8'he, "R11");

        repeat (2) @(negedge clk);
        done = 1'b1;
        finish_run();
    end

endmodule